// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes 28 asynchronous external interrupt pins and turns them into four shared interrupt request lines for a downstream interrupt controller. Each pin goes through a two-flop synchroniser and then an optional filter. The filter is either a fixed three-sample agreement check or a counting filter with a programmable width. The filtered level is then checked against one of five trigger conditions. A hit sets a sticky pending bit, and a per-pin mask gates that bit onto the pin's shared output line.

Software sets up one pin per write through the configuration port and writes whole-vector masks through the mask port. The pending vector is visible at the ports. When a shared line fires, the handler reads `pending` to find which pin caused it, then writes ones to clear the bits it has handled. Level-triggered pins set their bit again while their level stays active.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset, `pending` and `irq` are zero, every mask bit is 1 (masked), every pin's trigger mode is rising edge (code 3), and filters are disabled.
- R2: With the filter disabled, a change on a pin sets its pending bit on the fourth rising clock edge after the change, and not earlier.
- R3: Trigger mode codes select the edge types: code 2 = falling edge, code 3 = rising edge, code 4 = both edges. An edge of the other polarity does not set the bit.
- R4: Mode code 1 = high level and code 0 = low level. While the level is active, the pending bit is set every cycle, so a clear is followed by re-assertion one cycle later. Once the level is inactive, a clear stays in effect.
- R5: Writing `clr_bits` with `clr_wr` high clears each pending bit whose `clr_bits` bit is 1 and leaves the other bits unchanged. Pending bits are otherwise sticky.
- R6: An edge event that arrives in the same cycle as a clear of that bit takes precedence, so the bit remains set.
- R7: A mask bit of 1 keeps the pin off its shared output without affecting its pending bit. A mask write of 0 lets an already pending bit drive the output immediately after the write edge.
- R8: `irq[0]` is the OR of the active (pending and unmasked) bits of pins 0-3. `irq[1]` covers pins 4-11, `irq[2]` covers pins 12-19, and `irq[3]` covers pins 20-27.
- R9: The delay filter (`cfg_flt_en`=1, `cfg_flt_sel`=0) changes the filtered level only when three consecutive synchronised samples agree. A 2-cycle pulse is rejected, and a held change sets pending two cycles later than it would unfiltered.
- R10: The sampling filter (`cfg_flt_en`=1, `cfg_flt_sel`=1, width W) changes the filtered level only after the synchronised input has held the new value for W+1 consecutive cycles. A pulse of W cycles is rejected, and a held change sets pending W cycles later than it would unfiltered.
- R11: Mode codes 5, 6 and 7 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 28 | Raw external interrupt pins |
| cfg_wr | input | 1 | Write strobe for one pin's configuration |
| cfg_pin | input | 5 | Index of the pin being configured (indices of 28 and above are ignored) |
| cfg_mode | input | 3 | Trigger mode code |
| cfg_flt_en | input | 1 | Filter enable |
| cfg_flt_sel | input | 1 | Filter type: 0 = delay filter, 1 = sampling filter |
| cfg_width | input | 6 | Sampling filter width W |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 28 | New mask vector (1 = masked) |
| clr_wr | input | 1 | Pending clear strobe |
| clr_bits | input | 28 | Write-one-to-clear vector |
| pending | output | 28 | Sticky pending bits |
| irq | output | 4 | Shared interrupt request lines |

## Verification
Most faults inside this block appear on `pending` within a few cycles of the stimulus.

- A missing or extra register in the synchroniser or filter moves the edge at which a pending bit sets. The bench therefore samples one cycle before and one cycle after the predicted edge.
- A wrong mode decode sets a bit for an edge of the wrong polarity.
- A broken filter counter either lets a short pulse through or delays a held change by a different number of cycles.
- Mask and grouping faults appear only on `irq`, while `pending` stays correct, so every check compares both vectors.

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner #(
  parameter int NPIN = 28,
  parameter int WW   = 6,
  parameter int PW   = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            cfg_wr,
  input  logic [PW-1:0]   cfg_pin,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_flt_en,
  input  logic            cfg_flt_sel,
  input  logic [WW-1:0]   cfg_width,
  input  logic            mask_wr,
  input  logic [NPIN-1:0] mask_data,
  input  logic            clr_wr,
  input  logic [NPIN-1:0] clr_bits,
  output logic [NPIN-1:0] pending,
  output logic [3:0]      irq
);
  localparam int NOUT = 4;
  localparam logic [2:0] M_LOW = 3'd0, M_HIGH = 3'd1, M_FALL = 3'd2,
                         M_RISE = 3'd3, M_BOTH = 3'd4;

  logic [NPIN-1:0] sync1, sync2, mask_q, edge_hit, lvl_hit, clr_eff;
  logic [NPIN-1:0][2:0] mode_all;

  function automatic int group_of(int i);
    if (i < 4) return 0;
    else if (i < 12) return 1;
    else if (i < 20) return 2;
    else return 3;
  endfunction

  function automatic logic [NPIN-1:0] group_bits(int o);
    logic [NPIN-1:0] b;
    b = '0;
    for (int i = 0; i < NPIN; i++) b[i] = (group_of(i) == o);
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      mask_q <= '1;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_pin
      logic [2:0]    mode;
      logic          fen, fsel;
      logic [WW-1:0] wid, cnt;
      logic          h1, h2, lvl, lvl_d;
      logic          rise, fall;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode <= M_RISE;
          fen  <= 1'b0;
          fsel <= 1'b0;
          wid  <= '0;
        end else if (cfg_wr && cfg_pin == PW'(gi)) begin
          mode <= cfg_mode;
          fen  <= cfg_flt_en;
          fsel <= cfg_flt_sel;
          wid  <= cfg_width;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          h1    <= 1'b0;
          h2    <= 1'b0;
          lvl   <= 1'b0;
          lvl_d <= 1'b0;
          cnt   <= '0;
        end else begin
          h1    <= sync2[gi];
          h2    <= h1;
          lvl_d <= lvl;
          if (!fen) begin
            lvl <= sync2[gi];
            cnt <= '0;
          end else if (!fsel) begin
            if (sync2[gi] == h1 && h1 == h2) lvl <= sync2[gi];
            cnt <= '0;
          end else if (sync2[gi] == lvl) begin
            cnt <= '0;
          end else if (cnt == wid) begin
            lvl <= sync2[gi];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end

      assign rise = lvl & ~lvl_d;
      assign fall = ~lvl & lvl_d;

      always_comb begin
        edge_hit[gi] = 1'b0;
        lvl_hit[gi]  = 1'b0;
        case (mode)
          M_LOW:  lvl_hit[gi]  = ~lvl;
          M_HIGH: lvl_hit[gi]  = lvl;
          M_FALL: edge_hit[gi] = fall;
          M_RISE: edge_hit[gi] = rise;
          M_BOTH: edge_hit[gi] = rise | fall;
          default: ;
        endcase
      end

      assign mode_all[gi] = mode;
    end
  endgenerate

  assign clr_eff = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~clr_eff) | edge_hit | (lvl_hit & ~clr_eff);
  end

  genvar go;
  generate
    for (go = 0; go < NOUT; go++) begin : g_out
      assign irq[go] = |(pending & ~mask_q & group_bits(go));
    end
  endgenerate
endmodule

module ext_irq_conditioner_chk #(
  parameter int NPIN = 28
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr_wr,
  input logic [NPIN-1:0]      pending,
  input logic [3:0]           irq,
  input logic [NPIN-1:0]      mask_q,
  input logic [NPIN-1:0][2:0] mode_all
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pending == '0 && irq == '0 && mask_q == '1));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((pending & $past(pending)) == $past(pending)));

  p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (pending != '0));

  p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (irq == '0));

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_mode
      p_bad_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_all[gi] > 3'd4) |=> !$rose(pending[gi]));
    end
  endgenerate
endmodule

bind ext_irq_conditioner ext_irq_conditioner_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .pending(pending), .irq(irq),
  .mask_q(mask_q), .mode_all(mode_all)
);

// File: tb/ext_irq_conditioner_test.sv
`timescale 1ns/1ps
module ext_irq_conditioner_test;
  localparam int N = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic cfg_wr = 1'b0;
  logic [4:0] cfg_pin = '0;
  logic [2:0] cfg_mode = '0;
  logic cfg_flt_en = 1'b0, cfg_flt_sel = 1'b0;
  logic [5:0] cfg_width = '0;
  logic mask_wr = 1'b0;
  logic [N-1:0] mask_data = '0;
  logic clr_wr = 1'b0;
  logic [N-1:0] clr_bits = '0;
  logic [N-1:0] pending;
  logic [3:0] irq;

  always #2 clk = ~clk;

  ext_irq_conditioner uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_wr(cfg_wr), .cfg_pin(cfg_pin),
    .cfg_mode(cfg_mode), .cfg_flt_en(cfg_flt_en), .cfg_flt_sel(cfg_flt_sel),
    .cfg_width(cfg_width), .mask_wr(mask_wr), .mask_data(mask_data),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .pending(pending), .irq(irq)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] pend;
    logic [3:0]   irq;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] exp_mask = '1;

  function automatic logic [3:0] irq_of(logic [N-1:0] p, logic [N-1:0] m);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (p[i] && !m[i]) r[(i < 4) ? 0 : (i < 12) ? 1 : (i < 20) ? 2 : 3] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] bit_of(int i);
    return N'(1) << i;
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_state(string tag, logic [N-1:0] p);
    exp_t e;
    e.tag = tag;
    e.pend = p;
    e.irq = irq_of(p, exp_mask);
    sb.push_back(e);
  endtask

  task automatic cfg(int pin, logic [2:0] mode, logic fen, logic fsel, logic [5:0] w);
    cfg_wr = 1'b1; cfg_pin = 5'(pin); cfg_mode = mode;
    cfg_flt_en = fen; cfg_flt_sel = fsel; cfg_width = w;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic clr(logic [N-1:0] b);
    clr_wr = 1'b1; clr_bits = b;
    tick(1);
    clr_wr = 1'b0; clr_bits = '0;
  endtask

  task automatic set_mask(logic [N-1:0] m);
    mask_wr = 1'b1; mask_data = m;
    tick(1);
    mask_wr = 1'b0;
    exp_mask = m;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (pending !== e.pend || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: pending=%h irq=%h expected pending=%h irq=%h",
                 e.tag, pending, irq, e.pend, e.irq);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bnd[7];
    bnd = '{3, 4, 11, 12, 19, 20, 27};
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_state("R1 reset state", '0);
    // R1: masks reset to 1, default rising mode
    pin_in[0] = 1'b1; tick(4);
    expect_state("R1 masked default rising", bit_of(0));
    clr(bit_of(0));
    expect_state("R1 clear", '0);
    set_mask('0);

    // R2 latency
    pin_in[2] = 1'b1; tick(3);
    expect_state("R2 not before fourth edge", '0);
    tick(1);
    expect_state("R2 fourth edge", bit_of(2));

    // R5 write-one-to-clear
    pin_in[6] = 1'b1; tick(4);
    expect_state("R5 two pending", bit_of(2) | bit_of(6));
    clr(bit_of(2));
    expect_state("R5 selective clear", bit_of(6));
    tick(3);
    expect_state("R5 sticky", bit_of(6));
    clr(bit_of(6));
    expect_state("R5 cleared", '0);

    // R7 mask
    set_mask(bit_of(5));
    pin_in[5] = 1'b1; tick(4);
    expect_state("R7 masked pending kept", bit_of(5));
    set_mask('0);
    expect_state("R7 unmasked drives irq", bit_of(5));
    clr(bit_of(5));

    // R8 group boundaries
    foreach (bnd[k]) begin
      pin_in[bnd[k]] = 1'b1; tick(4);
      expect_state("R8 group boundary", bit_of(bnd[k]));
      clr(bit_of(bnd[k]));
      expect_state("R8 cleared", '0);
    end

    // R3 edge modes
    cfg(7, 3'd2, 1'b0, 1'b0, 6'd0);
    pin_in[7] = 1'b1; tick(4);
    expect_state("R3 falling ignores rise", '0);
    pin_in[7] = 1'b0; tick(4);
    expect_state("R3 falling fires", bit_of(7));
    clr(bit_of(7));
    cfg(8, 3'd4, 1'b0, 1'b0, 6'd0);
    pin_in[8] = 1'b1; tick(4);
    expect_state("R3 both on rise", bit_of(8));
    clr(bit_of(8));
    pin_in[8] = 1'b0; tick(4);
    expect_state("R3 both on fall", bit_of(8));
    clr(bit_of(8));
    pin_in[2] = 1'b0; tick(4);
    expect_state("R3 rising ignores fall", '0);

    // R4 level modes
    cfg(9, 3'd1, 1'b0, 1'b0, 6'd0);
    pin_in[9] = 1'b1; tick(4);
    expect_state("R4 high level", bit_of(9));
    clr(bit_of(9));
    expect_state("R4 clear while high", '0);
    tick(1);
    expect_state("R4 re-assert", bit_of(9));
    pin_in[9] = 1'b0; tick(4);
    clr(bit_of(9));
    expect_state("R4 clear after inactive", '0);
    tick(2);
    expect_state("R4 stays clear", '0);
    cfg(10, 3'd0, 1'b0, 1'b0, 6'd0);
    expect_state("R4 low level not yet", '0);
    tick(1);
    expect_state("R4 low level fires", bit_of(10));
    pin_in[10] = 1'b1; tick(4);
    clr(bit_of(10));
    tick(2);
    expect_state("R4 low level inactive", '0);

    // R6 edge beats clear
    pin_in[16] = 1'b1; tick(3);
    clr(bit_of(16));
    expect_state("R6 edge wins over clear", bit_of(16));
    clr(bit_of(16));
    expect_state("R6 cleared", '0);

    // R9 delay filter
    cfg(13, 3'd3, 1'b1, 1'b0, 6'd0);
    pin_in[13] = 1'b1; tick(2);
    pin_in[13] = 1'b0; tick(8);
    expect_state("R9 short pulse rejected", '0);
    pin_in[13] = 1'b1; tick(5);
    expect_state("R9 not before sixth edge", '0);
    tick(1);
    expect_state("R9 sixth edge", bit_of(13));
    clr(bit_of(13));

    // R10 sampling filter width 4
    cfg(14, 3'd3, 1'b1, 1'b1, 6'd4);
    pin_in[14] = 1'b1; tick(4);
    pin_in[14] = 1'b0; tick(12);
    expect_state("R10 W-cycle pulse rejected", '0);
    pin_in[14] = 1'b1; tick(7);
    expect_state("R10 not before edge 4+W", '0);
    tick(1);
    expect_state("R10 edge 4+W", bit_of(14));
    clr(bit_of(14));

    // R11 reserved modes
    cfg(15, 3'd5, 1'b0, 1'b0, 6'd0);
    cfg(17, 3'd7, 1'b0, 1'b0, 6'd0);
    pin_in[15] = 1'b1; pin_in[17] = 1'b1; tick(6);
    expect_state("R11 reserved mode rise", '0);
    pin_in[15] = 1'b0; pin_in[17] = 1'b0; tick(6);
    expect_state("R11 reserved mode fall", '0);

    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule